// File: doc/BRIEF.md
# Interlocked Shared-Bus Read Link

This block joins a requesting agent to a word store over one set of shared lines that carry first an address and then the returned word. Two state machines sit on either side of the lines: a requester that accepts a read command and hands back the word, and a responder that fetches the word from a synchronous array outside the block. They coordinate through three control levels: a request strobe, an acknowledge strobe that either side may raise, and a data-present strobe. Each side moves only on the levels it samples from the other.

One read runs as a fully interlocked exchange. The requester puts the address on the shared lines and raises its request. The responder takes the address and acknowledges. The requester lets go of the lines and drops the request, and the responder then drops its acknowledge. The responder places the word on the lines and raises data-present. The requester captures the word and acknowledges. The responder drops data-present and lets go of the lines, and the requester drops its acknowledge when it sees that. The array fetch runs while the request and the first acknowledge are being taken down. If either side waits longer than its own limit, it gives up, lets go of every line and pulses an error.

Top module: `async_read_link`

## Requirements
- R1: After reset, cmd_ready is 1, and lnk_req, lnk_ack, lnk_rdy, req_drive, rsp_drive, rsp_valid, req_err and rsp_err are all 0.
- R2: While lnk_req is 1, the requester drives the shared lines, and lnk_data equals the accepted address, zero-extended in its low ADDR_W bits.
- R3: The responder raises the acknowledge only after sampling lnk_req at 1, and the requester drops lnk_req only after sampling lnk_ack at 1.
- R4: The responder drops its first acknowledge only after sampling lnk_req at 0.
- R5: lnk_rdy rises only while lnk_ack is 0, and no sooner than MEM_LAT cycles after the acknowledge rose. While lnk_rdy is 1, lnk_data carries the array word at the latched address.
- R6: When the exchange ends, rsp_valid is 1 for exactly one cycle, and rsp_data equals the array word at the commanded address.
- R7: The responder drops lnk_rdy only after sampling lnk_ack at 1, and the requester drops its acknowledge only after sampling lnk_rdy at 0.
- R8: req_drive and rsp_drive are never both 1.
- R9: If the requester waits DEV_TIMEOUT cycles in one step, it pulses req_err for one cycle, lets go of all lines and returns to idle (cmd_ready 1) without a response.
- R10: If the responder waits MEM_TIMEOUT cycles in one step, it pulses rsp_err for one cycle, lowers lnk_rdy and rsp_drive, and returns to idle.
- R11: cmd_valid is ignored while cmd_ready is 0. The running read completes for its own address and produces a single response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Read command present |
| cmd_addr | input | ADDR_W | Word address of the read |
| cmd_ready | output | 1 | Requester idle; a command is taken this cycle |
| rsp_valid | output | 1 | One-cycle pulse with the returned word |
| rsp_data | output | DATA_W | Returned word |
| req_err | output | 1 | Requester wait limit reached (pulse) |
| rsp_err | output | 1 | Responder wait limit reached (pulse) |
| arr_rd | output | 1 | Array read strobe |
| arr_addr | output | ADDR_W | Array read address |
| arr_rdata | input | DATA_W | Array word, registered one cycle after arr_rd and held |
| lnk_data | output | DATA_W | Resolved value on the shared lines |
| lnk_req | output | 1 | Request strobe level |
| lnk_ack | output | 1 | Acknowledge level (either side) |
| lnk_rdy | output | 1 | Data-present strobe level |
| req_drive | output | 1 | Requester drives the shared lines |
| rsp_drive | output | 1 | Responder drives the shared lines |

## Verification
The embedded properties assume that the array returns the addressed word one cycle after arr_rd and holds it until the next strobe. They also assume that a new command never arrives while the responder is still finishing an exchange that the requester has abandoned. Otherwise the two sides could drive the lines at the same time. The stimulus keeps to both assumptions. The bench models the array as a registered read port. Random reads on the main instance use wait limits far above the handshake length. On the instance built with a short requester limit, the bench issues a new command only after the responder has also given up. Random commands during a busy read are kept off the final idle edge, so they can only fall into the window in which they must be ignored.

// File: rtl/aln_pkg.sv
package aln_pkg;

    typedef enum logic [1:0] {
        D_IDLE = 2'd0,
        D_REQ  = 2'd1,
        D_WAIT = 2'd2,
        D_ACK  = 2'd3
    } dev_state_e;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_ACK   = 3'd1,
        M_WAIT  = 3'd2,
        M_DRIVE = 3'd3,
        M_REL   = 3'd4
    } mem_state_e;

endpackage

// File: rtl/aln_req_side.sv
module aln_req_side
    import aln_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              req_o,
    output logic              ack_o,
    input  logic              ack_in,
    input  logic              rdy_in
);

    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        dev_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CW-1:0]     cnt;
        logic              rsp_valid;
        logic              err;
    } req_regs_t;

    req_regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.err       = 1'b0;
        case (r_q.state)
            D_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr  = cmd_addr;
                    r_d.state = D_REQ;
                    r_d.cnt   = '0;
                end
            end
            D_REQ: begin
                if (ack_in) begin
                    r_d.state = D_WAIT;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.state = D_IDLE;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            D_WAIT: begin
                if (rdy_in) begin
                    r_d.data  = bus_in;
                    r_d.state = D_ACK;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.state = D_IDLE;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            D_ACK: begin
                if (!rdy_in) begin
                    r_d.state     = D_IDLE;
                    r_d.rsp_valid = 1'b1;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.state = D_IDLE;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ready = (r_q.state == D_IDLE);
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_data  = r_q.data;
    assign err       = r_q.err;
    assign bus_oe    = (r_q.state == D_REQ);
    assign req_o     = (r_q.state == D_REQ);
    assign ack_o     = (r_q.state == D_ACK);

    generate
        if (DATA_W > ADDR_W) begin : g_pad
            assign bus_out = {{(DATA_W-ADDR_W){1'b0}}, r_q.addr};
        end else begin : g_nopad
            assign bus_out = r_q.addr[DATA_W-1:0];
        end
    endgenerate

    // R3: request released only once the acknowledge was seen
    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_o) && !err) |-> $past(ack_in));

    // R7: own acknowledge released only after data-present went low
    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_o) && !err) |-> !$past(rdy_in));

    // R6: a response follows the acknowledge phase
    p_rsp_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(ack_o) && !ack_o));

endmodule

// File: rtl/aln_rsp_side.sv
module aln_rsp_side
    import aln_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LAT     = 4,
    parameter int TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              err,
    output logic              arr_rd,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              req_in,
    output logic              ack_o,
    input  logic              ack_in,
    output logic              rdy_o
);

    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
    localparam int LW = $clog2(LAT + 1);
    localparam logic [LW-1:0] LAT_DONE = LW'(LAT);

    typedef struct packed {
        mem_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CW-1:0]     cnt;
        logic [LW-1:0]     lat;
        logic              rd;
        logic              err;
    } rsp_regs_t;

    rsp_regs_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rd  = 1'b0;
        s_d.err = 1'b0;
        if ((s_q.state == M_ACK || s_q.state == M_WAIT) && s_q.lat != LAT_DONE) begin
            s_d.lat = s_q.lat + 1'b1;
        end
        case (s_q.state)
            M_IDLE: begin
                if (req_in) begin
                    s_d.addr  = bus_in[ADDR_W-1:0];
                    s_d.state = M_ACK;
                    s_d.rd    = 1'b1;
                    s_d.lat   = '0;
                    s_d.cnt   = '0;
                end
            end
            M_ACK: begin
                if (!req_in) begin
                    s_d.state = M_WAIT;
                    s_d.cnt   = '0;
                end else if (s_q.cnt == CNT_LAST) begin
                    s_d.state = M_IDLE;
                    s_d.err   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            M_WAIT: begin
                if (s_q.lat == LAT_DONE) begin
                    s_d.data  = arr_rdata;
                    s_d.state = M_DRIVE;
                    s_d.cnt   = '0;
                end
            end
            M_DRIVE: begin
                if (ack_in) begin
                    s_d.state = M_REL;
                    s_d.cnt   = '0;
                end else if (s_q.cnt == CNT_LAST) begin
                    s_d.state = M_IDLE;
                    s_d.err   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            M_REL: begin
                if (!ack_in) begin
                    s_d.state = M_IDLE;
                end else if (s_q.cnt == CNT_LAST) begin
                    s_d.state = M_IDLE;
                    s_d.err   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err      = s_q.err;
    assign arr_rd   = s_q.rd;
    assign arr_addr = s_q.addr;
    assign bus_out  = s_q.data;
    assign bus_oe   = (s_q.state == M_DRIVE);
    assign rdy_o    = (s_q.state == M_DRIVE);
    assign ack_o    = (s_q.state == M_ACK);

    generate
        if (DATA_W > ADDR_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^bus_in[DATA_W-1:ADDR_W];
        end
    endgenerate

    // R3: acknowledge only in answer to a sampled request
    p_ack_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_in));

    // R4: first acknowledge held until the request was seen low
    p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_o) && !err) |-> !$past(req_in));

    // R5: data-present never rises over a live acknowledge
    p_rdy_quiet_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> (!ack_in && !ack_o));

    // R7: data-present dropped only after the requester acknowledged
    p_rdy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rdy_o) && !err) |-> $past(ack_in));

endmodule

// File: rtl/aln_bus_join.sv
module aln_bus_join #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] req_out,
    input  logic              req_oe,
    input  logic [DATA_W-1:0] rsp_out,
    input  logic              rsp_oe,
    input  logic              req_ack,
    input  logic              rsp_ack,
    output logic [DATA_W-1:0] bus,
    output logic              ack
);

    always_comb begin
        if (req_oe)      bus = req_out;
        else if (rsp_oe) bus = rsp_out;
        else             bus = '0;
    end

    assign ack = req_ack | rsp_ack;

    // R8: the shared lines have at most one driver
    p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_oe && rsp_oe));

endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int MEM_LAT     = 4,
    parameter int DEV_TIMEOUT = 32,
    parameter int MEM_TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              req_err,
    output logic              rsp_err,
    output logic              arr_rd,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] lnk_data,
    output logic              lnk_req,
    output logic              lnk_ack,
    output logic              lnk_rdy,
    output logic              req_drive,
    output logic              rsp_drive
);

    logic [DATA_W-1:0] req_out, rsp_out;
    logic              req_ack, rsp_ack;

    aln_req_side #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TIMEOUT(DEV_TIMEOUT)
    ) i_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_addr (cmd_addr),
        .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .err      (req_err),
        .bus_in   (lnk_data),
        .bus_out  (req_out),
        .bus_oe   (req_drive),
        .req_o    (lnk_req),
        .ack_o    (req_ack),
        .ack_in   (lnk_ack),
        .rdy_in   (lnk_rdy)
    );

    aln_rsp_side #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LAT    (MEM_LAT),
        .TIMEOUT(MEM_TIMEOUT)
    ) i_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .err      (rsp_err),
        .arr_rd   (arr_rd),
        .arr_addr (arr_addr),
        .arr_rdata(arr_rdata),
        .bus_in   (lnk_data),
        .bus_out  (rsp_out),
        .bus_oe   (rsp_drive),
        .req_in   (lnk_req),
        .ack_o    (rsp_ack),
        .ack_in   (lnk_ack),
        .rdy_o    (lnk_rdy)
    );

    aln_bus_join #(
        .DATA_W(DATA_W)
    ) i_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_out(req_out),
        .req_oe (req_drive),
        .rsp_out(rsp_out),
        .rsp_oe (rsp_drive),
        .req_ack(req_ack),
        .rsp_ack(rsp_ack),
        .bus    (lnk_data),
        .ack    (lnk_ack)
    );

endmodule

// File: tb/test_async_read_link.sv
module test_async_read_link;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int LAT  = 4;
    localparam int SLAT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        logic [31:0] p;
        p = {24'd0, a} * 32'h9E37 + 32'h1234;
        return p[DW-1:0] ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // main instance
    logic          m_cmd_valid = 1'b0;
    logic [AW-1:0] m_cmd_addr = '0;
    logic          m_cmd_ready, m_rsp_valid, m_req_err, m_rsp_err, m_arr_rd;
    logic [DW-1:0] m_rsp_data, m_lnk_data;
    logic [AW-1:0] m_arr_addr;
    logic [DW-1:0] m_arr_rdata = '0;
    logic          m_req, m_ack, m_rdy, m_qdrv, m_sdrv;

    async_read_link #(.ADDR_W(AW), .DATA_W(DW), .MEM_LAT(LAT),
                      .DEV_TIMEOUT(64), .MEM_TIMEOUT(64)) i_async_read_link (
        .clk(clk), .rst_n(rst_n), .cmd_valid(m_cmd_valid), .cmd_addr(m_cmd_addr),
        .cmd_ready(m_cmd_ready), .rsp_valid(m_rsp_valid), .rsp_data(m_rsp_data),
        .req_err(m_req_err), .rsp_err(m_rsp_err), .arr_rd(m_arr_rd),
        .arr_addr(m_arr_addr), .arr_rdata(m_arr_rdata), .lnk_data(m_lnk_data),
        .lnk_req(m_req), .lnk_ack(m_ack), .lnk_rdy(m_rdy),
        .req_drive(m_qdrv), .rsp_drive(m_sdrv));

    // instance with a requester limit shorter than the array latency
    logic          s_cmd_valid = 1'b0;
    logic [AW-1:0] s_cmd_addr = '0;
    logic          s_cmd_ready, s_rsp_valid, s_req_err, s_rsp_err, s_arr_rd;
    logic [DW-1:0] s_rsp_data, s_lnk_data;
    logic [AW-1:0] s_arr_addr;
    logic [DW-1:0] s_arr_rdata = '0;
    logic          s_req, s_ack, s_rdy, s_qdrv, s_sdrv;

    async_read_link #(.ADDR_W(AW), .DATA_W(DW), .MEM_LAT(SLAT),
                      .DEV_TIMEOUT(3), .MEM_TIMEOUT(5)) i_async_read_link_short (
        .clk(clk), .rst_n(rst_n), .cmd_valid(s_cmd_valid), .cmd_addr(s_cmd_addr),
        .cmd_ready(s_cmd_ready), .rsp_valid(s_rsp_valid), .rsp_data(s_rsp_data),
        .req_err(s_req_err), .rsp_err(s_rsp_err), .arr_rd(s_arr_rd),
        .arr_addr(s_arr_addr), .arr_rdata(s_arr_rdata), .lnk_data(s_lnk_data),
        .lnk_req(s_req), .lnk_ack(s_ack), .lnk_rdy(s_rdy),
        .req_drive(s_qdrv), .rsp_drive(s_sdrv));

    // registered array read ports
    always_ff @(posedge clk) begin
        if (m_arr_rd) m_arr_rdata <= word_at(m_arr_addr);
        if (s_arr_rd) s_arr_rdata <= word_at(s_arr_addr);
    end

    // driver conflicts and stray errors, sampled on falling edges
    int m_conflicts = 0;
    int s_conflicts = 0;
    int m_errs = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_qdrv && m_sdrv) m_conflicts++;
            if (s_qdrv && s_sdrv) s_conflicts++;
            if (m_req_err || m_rsp_err) m_errs++;
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input bit noisy);
        bit seen_req = 0, rdy_seen = 0, done = 0;
        bit p_req = 0, p_ack = 0, p_rdy = 0;
        int t_ack = 0;
        int n_rsp = 0;
        logic [DW-1:0] exp;
        exp = word_at(a);
        @(negedge clk);
        m_cmd_valid = 1'b1;
        m_cmd_addr  = a;
        @(negedge clk);
        m_cmd_valid = 1'b0;
        for (int c = 0; c < 200 && !done; c++) begin
            if (m_req && !seen_req) begin
                seen_req = 1;
                check(m_lnk_data == {{(DW-AW){1'b0}}, a} && m_qdrv, "R2 address on lines",
                      int'(m_lnk_data), int'(a));
            end
            if (m_ack && !p_ack && !rdy_seen) t_ack = c;
            if (p_req && !m_req)
                check(m_ack, "R3 request dropped only after acknowledge", int'(m_ack), 1);
            if (p_ack && !m_ack && !rdy_seen)
                check(!m_req, "R4 acknowledge dropped after request low", int'(m_req), 0);
            if (m_rdy && !p_rdy) begin
                rdy_seen = 1;
                check(!m_ack && (c - t_ack) >= LAT, "R5 data-present timing",
                      c - t_ack, LAT);
                check(m_lnk_data == exp, "R5 word on lines", int'(m_lnk_data), int'(exp));
            end
            if (p_rdy && !m_rdy)
                check(m_ack, "R7 data-present dropped after acknowledge", int'(m_ack), 1);
            if (p_ack && !m_ack && rdy_seen)
                check(!m_rdy, "R7 acknowledge dropped after data-present low", int'(m_rdy), 0);
            if (m_rsp_valid) begin
                n_rsp++;
                check(m_rsp_data == exp, "R6 returned word", int'(m_rsp_data), int'(exp));
                done = 1;
            end
            p_req = m_req; p_ack = m_ack; p_rdy = m_rdy;
            if (noisy && !rdy_seen && !done) begin
                m_cmd_valid = ($urandom_range(0, 1) == 1);
                m_cmd_addr  = ~a;
            end else begin
                m_cmd_valid = 1'b0;
            end
            if (!done) @(negedge clk);
        end
        check(done, "R6 response arrived", int'(done), 1);
        m_cmd_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (m_rsp_valid || m_req) n_rsp++;
        end
        check(n_rsp == 1, noisy ? "R11 single response under busy commands" : "R6 one-cycle response",
              n_rsp, 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check(m_cmd_ready && !m_req && !m_ack && !m_rdy && !m_qdrv && !m_sdrv &&
              !m_rsp_valid && !m_req_err && !m_rsp_err, "R1 state in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_cmd_ready && !m_req && !m_ack && !m_rdy && !m_qdrv && !m_sdrv,
              "R1 idle after reset", int'(m_cmd_ready), 1);

        // directed corners
        do_read(8'h00, 0);
        do_read(8'hFF, 0);
        do_read(8'hA5, 1);
        // random reads
        for (int i = 0; i < 40; i++) begin
            do_read(AW'($urandom_range(0, 255)), ($urandom_range(0, 3) == 0));
        end

        check(m_conflicts == 0, "R8 single driver, main", m_conflicts, 0);
        check(m_errs == 0, "R9/R10 no stray timeout on main", m_errs, 0);

        // timeout path on the short-limit instance
        begin
            int t_qerr = -1, t_serr = -1, rsp_seen = 0;
            bool_blk: begin end
            @(negedge clk);
            s_cmd_valid = 1'b1;
            s_cmd_addr  = 8'h3C;
            @(negedge clk);
            s_cmd_valid = 1'b0;
            for (int c = 0; c < 80; c++) begin
                if (s_rsp_valid) rsp_seen++;
                if (s_req_err && t_qerr < 0) begin
                    t_qerr = c;
                    check(!s_req && !s_qdrv && s_cmd_ready, "R9 requester released after timeout",
                          int'(s_req), 0);
                end
                if (s_rsp_err && t_serr < 0) begin
                    t_serr = c;
                    check(!s_rdy && !s_sdrv && !s_ack, "R10 responder released after timeout",
                          int'(s_rdy), 0);
                end
                @(negedge clk);
            end
            check(t_qerr >= 0, "R9 requester timeout flagged", t_qerr, 0);
            check(t_serr > t_qerr, "R10 responder timeout flagged", t_serr, t_qerr + 1);
            check(rsp_seen == 0, "R9 no response after timeout", rsp_seen, 0);
            check(!s_req_err && !s_rsp_err, "R10 error is a pulse", int'(s_rsp_err), 0);
        end
        check(s_conflicts == 0, "R8 single driver, short", s_conflicts, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R6 run did not end actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule